// File: doc/BRIEF.md
# Telemetry/Telecommand Request Scheduler

This block decides when a bus-controller host processor is asked to run a telecommand transfer or a telemetry poll. Telecommand requests arrive as single-cycle pulses whenever a user write occurs. Telemetry requests come from an internal time base. That time base divides the system clock by a first prescaler, then by a second one, then by a period count, which gives one tick per second at the default sizes. Each request type has its own interrupt line to the host: line 0 (`irq_tc`) for telecommand and line 1 (`irq_tm`) for telemetry.

A single lock lets only one operation run at a time. A request that arrives while the lock is held is kept pending and is issued once the running operation ends. Two requests are therefore serialized, and neither is lost. When both are pending in the same cycle, telecommand goes first. The host clears an interrupt line by acknowledging it. It ends the operation with a completion pulse, which carries a status word; the block stores that word and frees the lock. A telemetry tick that finds an earlier telemetry request still waiting is not queued twice. It is reported on a one-cycle overrun output.

Top module: `tmtc_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every output is 0 (`busy`, both interrupt lines, `tm_tick`, `tm_overrun`, `status_q`).
- R2: `tm_tick` is a one-cycle pulse that is high after rising edge number k·DIV_A·DIV_B·PERIOD (k ≥ 1). Edges are counted from the first edge that samples `rst` low.
- R3: When the block is idle with nothing pending, a `tc_req` sampled at edge e raises `irq_tc` and `busy` at edge e+1 after it.
- R4: When the block is idle with no telecommand pending, a `tm_tick` that is high at edge e raises `irq_tm` and `busy` at edge e+1.
- R5: Only one operation runs at a time. `busy` stays high until `op_done` is sampled. A request that arrived meanwhile is issued on the edge after the one that sampled `op_done`.
- R6: If a telecommand and a telemetry request are pending in the same cycle while idle, `irq_tc` is raised first and `irq_tm` stays low until that operation completes.
- R7: An interrupt line stays high until `irq_ack_tc`/`irq_ack_tm` for that line is sampled, or until `op_done` ends its operation. The two lines are never high together.
- R8: `op_done` sampled while `busy` loads `op_status` into `status_q` and drops `busy`. `op_done` while idle leaves `status_q` unchanged.
- R9: A telemetry tick that arrives while a telemetry request is pending and not being granted gives a one-cycle `tm_overrun` pulse. No second telemetry operation is queued.
- R10: Several `tc_req` pulses that arrive while one telecommand is already pending merge into a single telecommand operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tc_req | input | 1 | Telecommand request pulse (user write) |
| irq_ack_tc | input | 1 | Host acknowledge for interrupt line 0 |
| irq_ack_tm | input | 1 | Host acknowledge for interrupt line 1 |
| op_done | input | 1 | Completion pulse from host, releases the lock |
| op_status | input | STAT_W | Status word that comes with `op_done` |
| irq_tc | output | 1 | Interrupt line 0: telecommand to run |
| irq_tm | output | 1 | Interrupt line 1: telemetry poll to run |
| busy | output | 1 | Lock held, an operation is in progress |
| status_q | output | STAT_W | Status word of the last completed operation |
| tm_tick | output | 1 | Periodic telemetry tick pulse |
| tm_overrun | output | 1 | One-cycle pulse: telemetry tick found a request still pending |

## Verification
Directed sequences try single telecommand requests, bursts of requests while busy, a completion pulse while idle, a telecommand written in the very cycle of a tick, and an operation held over two tick periods. These tell apart, in order: plain issue timing, request merging, status protection, priority on collision, and overrun versus queuing. Random phases then mix sparse requests with acknowledges and completions at random delays, and sometimes hold the lock for more than a period. This compares the interrupt lines, the lock and the status word against a reference model every cycle, across many orderings of ticks and writes.

// File: rtl/tmtc_pkg.sv
package tmtc_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_TC   = 2'd1,
    LK_TM   = 2'd2
  } lock_e;

  function automatic int cw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tmtc_div_stage.sv
module tmtc_div_stage #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  output logic en_out
);
  import tmtc_pkg::*;
  localparam int W = cw(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (en_in) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign en_out = en_in && (cnt == LAST);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
endmodule

// File: rtl/tmtc_tick_gen.sv
module tmtc_tick_gen #(
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 32,
  parameter int PERIOD = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int NST = 3;
  localparam int DIVS [NST] = '{DIV_A, DIV_B, PERIOD};

  logic [NST:0] en;
  assign en[0] = 1'b1;

  for (genvar i = 0; i < NST; i++) begin : g_stage
    tmtc_div_stage #(.DIV(DIVS[i])) u_stage (
      .clk   (clk),
      .rst   (rst),
      .en_in (en[i]),
      .en_out(en[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= en[NST];
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/tmtc_lock_arb.sv
module tmtc_lock_arb #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tc_req,
  input  logic              ack_tc,
  input  logic              ack_tm,
  input  logic              done,
  input  logic [STAT_W-1:0] done_status,
  output logic              irq_tc,
  output logic              irq_tm,
  output logic              busy,
  output logic [STAT_W-1:0] status_q,
  output logic              overrun
);
  import tmtc_pkg::*;

  lock_e st;
  logic  pend_tc, pend_tm;
  logic  idle, grant_tc, grant_tm, fin_tc, fin_tm;

  assign idle     = (st == LK_IDLE);
  assign grant_tc = idle && pend_tc;
  assign grant_tm = idle && !pend_tc && pend_tm;
  assign fin_tc   = done && (st == LK_TC);
  assign fin_tm   = done && (st == LK_TM);
  assign busy     = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_tc  <= 1'b0;
      pend_tm  <= 1'b0;
      overrun  <= 1'b0;
      st       <= LK_IDLE;
      irq_tc   <= 1'b0;
      irq_tm   <= 1'b0;
      status_q <= '0;
    end else begin
      pend_tc <= tc_req | (pend_tc & ~grant_tc);
      pend_tm <= tick   | (pend_tm & ~grant_tm);
      overrun <= tick & pend_tm & ~grant_tm;
      irq_tc  <= grant_tc | (irq_tc & ~ack_tc & ~fin_tc);
      irq_tm  <= grant_tm | (irq_tm & ~ack_tm & ~fin_tm);
      if (grant_tc)      st <= LK_TC;
      else if (grant_tm) st <= LK_TM;
      else if (fin_tc || fin_tm) begin
        st       <= LK_IDLE;
        status_q <= done_status;
      end
    end
  end

  // R7
  one_line_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({irq_tc, irq_tm}));
  // R5
  tc_line_lock_chk: assert property (@(posedge clk) disable iff (rst) irq_tc |-> (st == LK_TC));
  // R5
  tm_line_lock_chk: assert property (@(posedge clk) disable iff (rst) irq_tm |-> (st == LK_TM));
  // R5
  lock_release_chk: assert property (@(posedge clk) disable iff (rst) (busy && done) |=> !busy);
  // R6
  tc_first_chk: assert property (@(posedge clk) disable iff (rst) (idle && pend_tc) |=> (st == LK_TC));
  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done) |=> $stable(status_q));
  // R9
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (rst) overrun |=> !overrun);
endmodule

// File: rtl/tmtc_sched.sv
module tmtc_sched #(
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 32,
  parameter int PERIOD = 250000,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tc_req,
  input  logic              irq_ack_tc,
  input  logic              irq_ack_tm,
  input  logic              op_done,
  input  logic [STAT_W-1:0] op_status,
  output logic              irq_tc,
  output logic              irq_tm,
  output logic              busy,
  output logic [STAT_W-1:0] status_q,
  output logic              tm_tick,
  output logic              tm_overrun
);
  tmtc_tick_gen #(
    .DIV_A (DIV_A),
    .DIV_B (DIV_B),
    .PERIOD(PERIOD)
  ) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tm_tick)
  );

  tmtc_lock_arb #(.STAT_W(STAT_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .tick       (tm_tick),
    .tc_req     (tc_req),
    .ack_tc     (irq_ack_tc),
    .ack_tm     (irq_ack_tm),
    .done       (op_done),
    .done_status(op_status),
    .irq_tc     (irq_tc),
    .irq_tm     (irq_tm),
    .busy       (busy),
    .status_q   (status_q),
    .overrun    (tm_overrun)
  );
endmodule

// File: tb/tmtc_sched_bench.sv
module tmtc_sched_bench;
  localparam int DA = 4, DB = 32, PER = 4, SW = 16;
  localparam int N = DA * DB * PER;

  logic clk = 1'b0, rst = 1'b1;
  logic tc_req = 0, ack_tc = 0, ack_tm = 0, done = 0;
  logic [SW-1:0] dstat = '0;
  logic irq_tc, irq_tm, busy, tm_tick, tm_overrun;
  logic [SW-1:0] status_q;

  int vecs = 0, fails = 0, cyc = 0, wd = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tmtc_sched #(.DIV_A(DA), .DIV_B(DB), .PERIOD(PER), .STAT_W(SW)) u_tmtc_sched (
    .clk(clk), .rst(rst), .tc_req(tc_req), .irq_ack_tc(ack_tc), .irq_ack_tm(ack_tm),
    .op_done(done), .op_status(dstat), .irq_tc(irq_tc), .irq_tm(irq_tm), .busy(busy),
    .status_q(status_q), .tm_tick(tm_tick), .tm_overrun(tm_overrun));

  function automatic bit exp_tick(input int c);
    return (c != 0) && (c % N == 0);
  endfunction

  // reference model built from the requirements
  logic m_ptc, m_ptm, m_ovr, m_itc, m_itm;
  logic [1:0] m_st;
  logic [SW-1:0] m_stat;

  always @(posedge clk) begin
    if (rst) begin
      cyc <= 0;
      m_ptc <= 0; m_ptm <= 0; m_ovr <= 0; m_itc <= 0; m_itm <= 0;
      m_st <= 0; m_stat <= '0;
    end else begin
      automatic bit tk = exp_tick(cyc);
      automatic bit gtc = (m_st == 0) && m_ptc;
      automatic bit gtm = (m_st == 0) && !m_ptc && m_ptm;
      cyc   <= cyc + 1;
      m_ptc <= tc_req | (m_ptc & !gtc);
      m_ptm <= tk | (m_ptm & !gtm);
      m_ovr <= tk & m_ptm & !gtm;
      m_itc <= gtc | (m_itc & !ack_tc & !(done && m_st == 1));
      m_itm <= gtm | (m_itm & !ack_tm & !(done && m_st == 2));
      if (gtc) m_st <= 1;
      else if (gtm) m_st <= 2;
      else if (m_st != 0 && done) begin
        m_st <= 0;
        m_stat <= dstat;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  bit model_on = 0;
  int ovr_seen = 0;
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R2 tm_tick", tm_tick, exp_tick(cyc));
      chk("R3 irq_tc", irq_tc, m_itc);
      chk("R4 irq_tm", irq_tm, m_itm);
      chk("R5 busy", busy, m_st != 0);
      chk("R8 status_q", status_q, m_stat);
      chk("R9 tm_overrun", tm_overrun, m_ovr);
      if (tm_overrun) ovr_seen++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  initial begin
    int s;
    int hold;
    s = $urandom(32'hC0FFEE);
    repeat (4) step();
    // R1 outputs during reset
    chk("R1 reset busy", busy, 0);
    chk("R1 reset irq", {irq_tc, irq_tm}, 0);
    chk("R1 reset tick/ovr", {tm_tick, tm_overrun}, 0);
    chk("R1 reset status", status_q, 0);
    rst = 0;
    step();
    chk("R1 after reset", {busy, irq_tc, irq_tm, tm_tick, tm_overrun}, 0);
    model_on = 1;

    // R3 single request
    tc_req = 1; step(); tc_req = 0; step();
    chk("R3 irq_tc raised", irq_tc, 1);
    chk("R3 busy raised", busy, 1);
    // R7 line held without ack
    repeat (5) step();
    chk("R7 irq_tc held", irq_tc, 1);
    // R10 burst while busy
    repeat (3) begin tc_req = 1; step(); tc_req = 0; step(); end
    chk("R10 still one op", {irq_tc, busy}, 2'b11);
    ack_tc = 1; step(); ack_tc = 0;
    chk("R7 ack clears line", irq_tc, 0);
    chk("R5 lock kept after ack", busy, 1);
    done = 1; dstat = 16'hA5A5; step(); done = 0;
    chk("R8 status loaded", status_q, 16'hA5A5);
    chk("R8 lock released", busy, 0);
    step();
    chk("R5 held request issued", irq_tc, 1);
    done = 1; dstat = 16'h3C3C; step(); done = 0;
    chk("R7 done clears line", irq_tc, 0);
    chk("R8 status loaded 2", status_q, 16'h3C3C);
    repeat (3) step();
    chk("R10 merged to one op", busy, 0);
    done = 1; dstat = 16'h1234; step(); done = 0;
    chk("R8 idle done ignored", status_q, 16'h3C3C);

    // R6 collision with tick
    while (!exp_tick(cyc)) step();
    chk("R2 tick at period", tm_tick, 1);
    tc_req = 1; step(); tc_req = 0; step();
    chk("R6 tc first", {irq_tc, irq_tm}, 2'b10);
    done = 1; dstat = 16'h0001; step(); done = 0;
    chk("R6 tm waits", irq_tm, 0);
    step();
    chk("R4 tm after tc", irq_tm, 1);
    ack_tm = 1; step(); ack_tm = 0;
    done = 1; dstat = 16'h0002; step(); done = 0;

    // R9 overrun over two periods
    step();
    tc_req = 1; step(); tc_req = 0;
    ovr_seen = 0;
    repeat (2 * N) step();
    chk("R9 one overrun", ovr_seen, 1);
    done = 1; step(); done = 0; step();
    chk("R9 single tm queued", irq_tm, 1);
    done = 1; step(); done = 0;
    repeat (3) step();
    chk("R9 no second tm", busy, 0);

    // random phase
    hold = 0;
    for (int i = 0; i < 30000; i++) begin
      tc_req = ($urandom % 25) == 0;
      ack_tc = m_itc && (($urandom % 4) == 0);
      ack_tm = m_itm && (($urandom % 4) == 0);
      if (hold > 0) begin hold--; done = 0; end
      else begin
        done = ($urandom % 8) == 0;
        if (($urandom % 3000) == 0) hold = 1300;
      end
      dstat = SW'($urandom);
      step();
    end
    tc_req = 0; ack_tc = 0; ack_tm = 0; done = 0;
    step();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule